// File: doc/BRIEF.md
# Boot Image Stream Producer

This block holds a short, fixed start-up program in a read-only table and sends it downstream exactly once, one 32-bit word per beat, over a valid/ready handshake that marks the final beat with a last flag. A single-cycle go pulse starts the transfer. Two status outputs report progress: busy while words are still being sent, and done after the final word has been taken. A done block starts again only after reset.

Beside the data stream the block emits a trace record stream. There is one record when the transfer starts, one for every word the sink accepts, and one when the transfer completes. Every record carries a subsystem code, the block's master identifier, a word index and a data word. The image contents are computed when the design is elaborated. They cannot be changed at run time.

Top module: `bootimg_streamer`

## Requirements
- R1: While reset is asserted, and for the first two clock edges after `rst_n` rises, `beat_valid_o`, `beat_last_o`, `busy_o`, `done_o` and `ev_valid_o` are all low.
- R2: A go pulse sampled while the block is idle and not done makes `busy_o` and `beat_valid_o` high in the next cycle, with word index 0 on the stream. In that same cycle a start record appears: `ev_kind_o` = 1, `ev_index_o` = 0, `ev_word_o` = IMG_WORDS.
- R3: Beat k carries the image word k. Words 0..3 are 0x401A7000, 0x275A0004, 0x03400008 and 0x42000010. From word 4 on, even-indexed words are 0x03E00008 and odd-indexed words are 0x00000000, up to word IMG_WORDS-1 (default IMG_WORDS = 96).
- R4: A beat is taken only at a clock edge where `beat_valid_o` and `beat_ready_i` are both high. While `beat_ready_i` is low, `beat_valid_o`, `beat_data_o` and `beat_last_o` hold their values.
- R5: `beat_last_o` is high only together with `beat_valid_o`, and only on word IMG_WORDS-1.
- R6: In the cycle after the last beat is taken, `beat_valid_o` and `busy_o` are low and `done_o` is high. `done_o` stays high until reset, and `busy_o` and `done_o` are never high together.
- R7: In the cycle after each accepted beat, a beat record appears: `ev_kind_o` = 2, `ev_index_o` = the word index, `ev_word_o` = the word that was taken. Exactly IMG_WORDS beat records are produced per transfer.
- R8: Exactly one done record is produced, two cycles after the last beat is taken: `ev_kind_o` = 3, `ev_index_o` = IMG_WORDS, `ev_word_o` = 0.
- R9: Every record (`ev_valid_o` high for one cycle per record) carries `ev_subsys_o` = 4'h3, the DMA subsystem code, and `ev_master_o` = MASTER_ID (default 6).
- R10: A go pulse while `busy_o` or `done_o` is high has no effect. No extra start record appears, and the stream continues or stays idle exactly as it would without the pulse.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously inside the block |
| go_i | input | 1 | Single-cycle start pulse |
| beat_valid_o | output | 1 | Stream word valid |
| beat_data_o | output | 32 | Stream word |
| beat_last_o | output | 1 | Marks the final word |
| beat_ready_i | input | 1 | Sink accepts the current word |
| busy_o | output | 1 | Transfer in progress |
| done_o | output | 1 | Transfer complete (sticky until reset) |
| ev_valid_o | output | 1 | Trace record valid |
| ev_kind_o | output | 2 | Record kind: 1 start, 2 beat, 3 done |
| ev_subsys_o | output | 4 | Subsystem code of the record |
| ev_master_o | output | 8 | Master identifier of the record |
| ev_index_o | output | IDX_W | Word index argument, IDX_W = clog2(IMG_WORDS+1) |
| ev_word_o | output | 32 | Data word argument |

## Verification
Every result is registered. The stream outputs, busy and the start record change one cycle after the go edge. Done, the deassertion of valid and each beat record follow one cycle after the accepting edge. The done record follows two cycles after the final accepting edge, and the block ignores go for two edges after reset is released. The bench model applies the same edges to go, ready and reset that the design sees, updates its state on each rising edge, and compares every output at the following falling edge. No result is sampled at an edge where it can change. The bench drives ready in three patterns: always high, pseudo-random, and one accept in seven cycles. It also sends go pulses during busy and after done, and applies a reset partway through a transfer.

// File: rtl/bootimg_pkg.sv
package bootimg_pkg;

  localparam int unsigned WORD_W = 32;
  localparam logic [3:0]  SUBSYS_DMA = 4'h3;

  typedef enum logic [1:0] {
    EVK_NONE  = 2'd0,
    EVK_START = 2'd1,
    EVK_BEAT  = 2'd2,
    EVK_DONE  = 2'd3
  } ev_kind_e;

  typedef enum logic [1:0] {
    ST_IDLE   = 2'd0,
    ST_STREAM = 2'd1,
    ST_DONE   = 2'd2
  } seq_state_e;

  // Start-up program: a four-word prologue, then return/no-op pairs.
  function automatic logic [WORD_W-1:0] image_word(input int unsigned idx);
    logic [WORD_W-1:0] w;
    case (idx)
      0:       w = 32'h401A_7000;
      1:       w = 32'h275A_0004;
      2:       w = 32'h0340_0008;
      3:       w = 32'h4200_0010;
      default: w = (idx % 2 == 0) ? 32'h03E0_0008 : 32'h0000_0000;
    endcase
    return w;
  endfunction

endpackage

// File: rtl/bootimg_rst_sync.sv
module bootimg_rst_sync #(
  parameter int unsigned STAGES = 2
) (
  input  logic clk,
  input  logic rst_n,
  output logic rst_n_sync_o
);

  logic [STAGES-1:0] sync_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      sync_q <= '0;
    end else begin
      sync_q <= {sync_q[STAGES-2:0], 1'b1};
    end
  end

  assign rst_n_sync_o = sync_q[STAGES-1];

endmodule

// File: rtl/bootimg_rom.sv
module bootimg_rom
  import bootimg_pkg::*;
#(
  parameter int unsigned IMG_WORDS = 96,
  parameter int unsigned IDX_W     = 7
) (
  input  logic [IDX_W-1:0]  rd_idx_i,
  output logic [WORD_W-1:0] rd_data_o
);

  logic [WORD_W-1:0] rom [IMG_WORDS];

  for (genvar g = 0; g < IMG_WORDS; g++) begin : g_word
    assign rom[g] = image_word(g);
  end

  assign rd_data_o = (rd_idx_i < IDX_W'(IMG_WORDS)) ? rom[rd_idx_i] : '0;

endmodule

// File: rtl/bootimg_seq.sv
module bootimg_seq
  import bootimg_pkg::*;
#(
  parameter int unsigned IMG_WORDS = 96,
  parameter int unsigned IDX_W     = 7
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             go_i,
  input  logic             ready_i,
  output seq_state_e       state_o,
  output logic [IDX_W-1:0] idx_o,
  output logic             accept_o,
  output logic             last_idx_o,
  output logic             start_fire_o,
  output logic             done_fire_o
);

  localparam logic [IDX_W-1:0] LAST_IDX = IDX_W'(IMG_WORDS - 1);

  seq_state_e       state_q, state_d;
  logic [IDX_W-1:0] idx_q, idx_d;
  logic             idx_en;
  logic             done_sent_q, done_sent_d, done_sent_en;
  logic             accept, last_idx, start_fire, done_fire;

  assign last_idx   = (idx_q == LAST_IDX);
  assign accept     = (state_q == ST_STREAM) && ready_i;
  assign start_fire = (state_q == ST_IDLE) && go_i;
  assign done_fire  = (state_q == ST_DONE) && !done_sent_q;

  always_comb begin
    state_d      = state_q;
    idx_d        = idx_q;
    idx_en       = 1'b0;
    done_sent_d  = done_sent_q;
    done_sent_en = 1'b0;
    case (state_q)
      ST_IDLE: begin
        if (go_i) begin
          state_d = ST_STREAM;
          idx_d   = '0;
          idx_en  = 1'b1;
        end
      end
      ST_STREAM: begin
        if (accept) begin
          if (last_idx) begin
            state_d = ST_DONE;
          end else begin
            idx_d  = idx_q + 1'b1;
            idx_en = 1'b1;
          end
        end
      end
      ST_DONE: begin
        if (done_fire) begin
          done_sent_d  = 1'b1;
          done_sent_en = 1'b1;
        end
      end
      default: begin
        state_d = ST_IDLE;
      end
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state_q     <= ST_IDLE;
      idx_q       <= '0;
      done_sent_q <= 1'b0;
    end else begin
      state_q <= state_d;
      if (idx_en) begin
        idx_q <= idx_d;
      end
      if (done_sent_en) begin
        done_sent_q <= done_sent_d;
      end
    end
  end

  assign state_o      = state_q;
  assign idx_o        = idx_q;
  assign accept_o     = accept;
  assign last_idx_o   = last_idx;
  assign start_fire_o = start_fire;
  assign done_fire_o  = done_fire;

endmodule

// File: rtl/bootimg_trace.sv
module bootimg_trace
  import bootimg_pkg::*;
#(
  parameter int unsigned IMG_WORDS = 96,
  parameter int unsigned IDX_W     = 7,
  parameter logic [7:0]  MASTER_ID = 8'd6
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              start_fire_i,
  input  logic              accept_i,
  input  logic              done_fire_i,
  input  logic [IDX_W-1:0]  idx_i,
  input  logic [WORD_W-1:0] word_i,
  output logic              ev_valid_o,
  output logic [1:0]        ev_kind_o,
  output logic [3:0]        ev_subsys_o,
  output logic [7:0]        ev_master_o,
  output logic [IDX_W-1:0]  ev_index_o,
  output logic [WORD_W-1:0] ev_word_o
);

  logic              valid_q, valid_d;
  ev_kind_e          kind_q, kind_d;
  logic [IDX_W-1:0]  index_q, index_d;
  logic [WORD_W-1:0] word_q, word_d;
  logic              payload_en;

  always_comb begin
    valid_d    = 1'b0;
    kind_d     = EVK_NONE;
    index_d    = index_q;
    word_d     = word_q;
    payload_en = 1'b0;
    if (start_fire_i) begin
      valid_d    = 1'b1;
      kind_d     = EVK_START;
      index_d    = '0;
      word_d     = WORD_W'(IMG_WORDS);
      payload_en = 1'b1;
    end else if (accept_i) begin
      valid_d    = 1'b1;
      kind_d     = EVK_BEAT;
      index_d    = idx_i;
      word_d     = word_i;
      payload_en = 1'b1;
    end else if (done_fire_i) begin
      valid_d    = 1'b1;
      kind_d     = EVK_DONE;
      index_d    = IDX_W'(IMG_WORDS);
      word_d     = '0;
      payload_en = 1'b1;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      valid_q <= 1'b0;
      kind_q  <= EVK_NONE;
      index_q <= '0;
      word_q  <= '0;
    end else begin
      valid_q <= valid_d;
      kind_q  <= kind_d;
      if (payload_en) begin
        index_q <= index_d;
        word_q  <= word_d;
      end
    end
  end

  assign ev_valid_o  = valid_q;
  assign ev_kind_o   = kind_q;
  assign ev_subsys_o = valid_q ? SUBSYS_DMA : 4'h0;
  assign ev_master_o = valid_q ? MASTER_ID : 8'h00;
  assign ev_index_o  = index_q;
  assign ev_word_o   = word_q;

endmodule

// File: rtl/bootimg_streamer.sv
module bootimg_streamer
  import bootimg_pkg::*;
#(
  parameter int unsigned IMG_WORDS = 96,
  parameter logic [7:0]  MASTER_ID = 8'd6,
  localparam int unsigned IDX_W    = $clog2(IMG_WORDS + 1)
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             go_i,
  output logic             beat_valid_o,
  output logic [31:0]      beat_data_o,
  output logic             beat_last_o,
  input  logic             beat_ready_i,
  output logic             busy_o,
  output logic             done_o,
  output logic             ev_valid_o,
  output logic [1:0]       ev_kind_o,
  output logic [3:0]       ev_subsys_o,
  output logic [7:0]       ev_master_o,
  output logic [IDX_W-1:0] ev_index_o,
  output logic [31:0]      ev_word_o
);

  logic              rst_n_int;
  seq_state_e        state;
  logic [IDX_W-1:0]  idx;
  logic              accept, last_idx, start_fire, done_fire;
  logic [WORD_W-1:0] rom_word;

  bootimg_rst_sync #(.STAGES(2)) u_rst_sync (
    .clk          (clk),
    .rst_n        (rst_n),
    .rst_n_sync_o (rst_n_int)
  );

  bootimg_seq #(.IMG_WORDS(IMG_WORDS), .IDX_W(IDX_W)) u_seq (
    .clk          (clk),
    .rst_n        (rst_n_int),
    .go_i         (go_i),
    .ready_i      (beat_ready_i),
    .state_o      (state),
    .idx_o        (idx),
    .accept_o     (accept),
    .last_idx_o   (last_idx),
    .start_fire_o (start_fire),
    .done_fire_o  (done_fire)
  );

  bootimg_rom #(.IMG_WORDS(IMG_WORDS), .IDX_W(IDX_W)) u_rom (
    .rd_idx_i  (idx),
    .rd_data_o (rom_word)
  );

  bootimg_trace #(.IMG_WORDS(IMG_WORDS), .IDX_W(IDX_W), .MASTER_ID(MASTER_ID)) u_trace (
    .clk          (clk),
    .rst_n        (rst_n_int),
    .start_fire_i (start_fire),
    .accept_i     (accept),
    .done_fire_i  (done_fire),
    .idx_i        (idx),
    .word_i       (rom_word),
    .ev_valid_o   (ev_valid_o),
    .ev_kind_o    (ev_kind_o),
    .ev_subsys_o  (ev_subsys_o),
    .ev_master_o  (ev_master_o),
    .ev_index_o   (ev_index_o),
    .ev_word_o    (ev_word_o)
  );

  assign beat_valid_o = (state == ST_STREAM);
  assign beat_data_o  = rom_word;
  assign beat_last_o  = (state == ST_STREAM) && last_idx;
  assign busy_o       = (state == ST_STREAM);
  assign done_o       = (state == ST_DONE);

endmodule

// File: rtl/bootimg_streamer_chk.sv
module bootimg_streamer_chk #(
  parameter int unsigned IMG_WORDS = 96,
  parameter logic [7:0]  MASTER_ID = 8'd6,
  parameter int unsigned IDX_W     = 7
) (
  input logic             clk,
  input logic             rst_n,
  input logic             go_i,
  input logic             beat_valid_o,
  input logic [31:0]      beat_data_o,
  input logic             beat_last_o,
  input logic             beat_ready_i,
  input logic             busy_o,
  input logic             done_o,
  input logic             ev_valid_o,
  input logic [1:0]       ev_kind_o,
  input logic [3:0]       ev_subsys_o,
  input logic [7:0]       ev_master_o,
  input logic [IDX_W-1:0] ev_index_o,
  input logic [31:0]      ev_word_o
);

  assert_hold_R4: assert property (@(posedge clk) disable iff (!rst_n)
    beat_valid_o && !beat_ready_i |=> beat_valid_o && $stable(beat_data_o) && $stable(beat_last_o));

  assert_last_valid_R5: assert property (@(posedge clk) disable iff (!rst_n)
    beat_last_o |-> beat_valid_o);

  assert_busy_done_excl_R6: assert property (@(posedge clk) disable iff (!rst_n)
    !(busy_o && done_o));

  assert_done_sticky_R6: assert property (@(posedge clk) disable iff (!rst_n)
    done_o |=> done_o);

  assert_last_to_done_R6: assert property (@(posedge clk) disable iff (!rst_n)
    beat_valid_o && beat_ready_i && beat_last_o |=> done_o && !beat_valid_o && !busy_o);

  assert_beat_event_R7: assert property (@(posedge clk) disable iff (!rst_n)
    beat_valid_o && beat_ready_i |=> ev_valid_o && ev_kind_o == 2'd2 && ev_word_o == $past(beat_data_o));

  assert_event_tag_R9: assert property (@(posedge clk) disable iff (!rst_n)
    ev_valid_o |-> ev_subsys_o == 4'h3 && ev_master_o == MASTER_ID);

  assert_go_ignored_R10: assert property (@(posedge clk) disable iff (!rst_n)
    (busy_o || done_o) && go_i |=> !(ev_valid_o && ev_kind_o == 2'd1));

endmodule

bind bootimg_streamer bootimg_streamer_chk #(
  .IMG_WORDS (IMG_WORDS),
  .MASTER_ID (MASTER_ID),
  .IDX_W     (IDX_W)
) chk_i (
  .clk          (clk),
  .rst_n        (rst_n),
  .go_i         (go_i),
  .beat_valid_o (beat_valid_o),
  .beat_data_o  (beat_data_o),
  .beat_last_o  (beat_last_o),
  .beat_ready_i (beat_ready_i),
  .busy_o       (busy_o),
  .done_o       (done_o),
  .ev_valid_o   (ev_valid_o),
  .ev_kind_o    (ev_kind_o),
  .ev_subsys_o  (ev_subsys_o),
  .ev_master_o  (ev_master_o),
  .ev_index_o   (ev_index_o),
  .ev_word_o    (ev_word_o)
);

// File: tb/bootimg_streamer_tb_top.sv
`timescale 1ns/1ps
module bootimg_streamer_tb_top;

  localparam int N     = 96;
  localparam int IDX_W = $clog2(N + 1);
  localparam logic [7:0] MID = 8'd6;

  logic             clk;
  logic             rst_n;
  logic             go;
  logic             ready;
  logic             beat_valid, beat_last, busy, done;
  logic [31:0]      beat_data;
  logic             ev_valid;
  logic [1:0]       ev_kind;
  logic [3:0]       ev_subsys;
  logic [7:0]       ev_master;
  logic [IDX_W-1:0] ev_index;
  logic [31:0]      ev_word;

  bootimg_streamer #(.IMG_WORDS(N), .MASTER_ID(MID)) dut_i (
    .clk(clk), .rst_n(rst_n), .go_i(go),
    .beat_valid_o(beat_valid), .beat_data_o(beat_data), .beat_last_o(beat_last),
    .beat_ready_i(ready), .busy_o(busy), .done_o(done),
    .ev_valid_o(ev_valid), .ev_kind_o(ev_kind), .ev_subsys_o(ev_subsys),
    .ev_master_o(ev_master), .ev_index_o(ev_index), .ev_word_o(ev_word)
  );

  initial clk = 1'b0;
  always #4 clk = ~clk;

  int n_checks = 0;
  int n_fail   = 0;

  task automatic chk(input bit ok, input string req, input longint act, input longint exp);
    n_checks++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s: actual 0x%0h expected 0x%0h at %0t", req, act, exp, $time);
    end
  endtask

  function automatic logic [31:0] exp_word(input int i);
    if (i == 0) return 32'h401A7000;
    if (i == 1) return 32'h275A0004;
    if (i == 2) return 32'h03400008;
    if (i == 3) return 32'h42000010;
    return (i % 2 == 0) ? 32'h03E00008 : 32'h0;
  endfunction

  // Reference model: 0 idle, 1 streaming, 2 done
  int m_st = 0, m_idx = 0, m_rel = 0;
  bit m_pend = 0;
  bit m_ev = 0;
  int m_kind = 0, m_eidx = 0;
  logic [31:0] m_eword = '0;

  always @(posedge clk) begin
    m_ev = 0;
    if (!rst_n) begin
      m_st = 0; m_idx = 0; m_pend = 0; m_rel = 0;
    end else if (m_rel < 2) begin
      m_rel++;
    end else if (m_st == 0 && go) begin
      m_st = 1; m_idx = 0; m_ev = 1; m_kind = 1; m_eidx = 0; m_eword = N;
    end else if (m_st == 1 && ready) begin
      m_ev = 1; m_kind = 2; m_eidx = m_idx; m_eword = exp_word(m_idx);
      if (m_idx == N - 1) begin m_st = 2; m_pend = 1; end
      else m_idx++;
    end else if (m_st == 2 && m_pend) begin
      m_ev = 1; m_kind = 3; m_eidx = N; m_eword = 0; m_pend = 0;
    end
  end

  int cnt_start = 0, cnt_beat = 0, cnt_done = 0;

  always @(negedge clk) begin
    chk(beat_valid == (m_st == 1), "R4 valid", beat_valid, m_st == 1);
    chk(busy == (m_st == 1), "R6 busy", busy, m_st == 1);
    chk(done == (m_st == 2), "R6 done", done, m_st == 2);
    chk(beat_last == (m_st == 1 && m_idx == N - 1), "R5 last", beat_last, m_st == 1 && m_idx == N - 1);
    if (m_st == 1) chk(beat_data == exp_word(m_idx), "R3 data", beat_data, exp_word(m_idx));
    chk(ev_valid == m_ev, "R7 ev_valid", ev_valid, m_ev);
    if (ev_valid && m_ev) begin
      chk(ev_kind == m_kind, "R8 ev_kind", ev_kind, m_kind);
      chk(ev_index == m_eidx, "R7 ev_index", ev_index, m_eidx);
      chk(ev_word == m_eword, "R7 ev_word", ev_word, m_eword);
      chk(ev_subsys == 4'h3, "R9 subsys", ev_subsys, 4'h3);
      chk(ev_master == MID, "R9 master", ev_master, MID);
    end
    if (ev_valid) begin
      if (ev_kind == 2'd1) cnt_start++;
      if (ev_kind == 2'd2) cnt_beat++;
      if (ev_kind == 2'd3) cnt_done++;
    end
  end

  int mode = 0;
  logic [15:0] lfsr = 16'hACE1;
  int cyc = 0;

  task automatic tick(input logic g);
    @(negedge clk);
    cyc++;
    lfsr = {lfsr[14:0], lfsr[15] ^ lfsr[13] ^ lfsr[12] ^ lfsr[10]};
    go = g;
    case (mode)
      0: ready = 1'b1;
      1: ready = lfsr[0];
      default: ready = (cyc % 7 == 0);
    endcase
  endtask

  task automatic do_reset();
    @(negedge clk);
    #1 rst_n = 1'b0;
    repeat (3) tick(1'b0);
    #1 rst_n = 1'b1;
    repeat (4) tick(1'b0);
    cnt_start = 0; cnt_beat = 0; cnt_done = 0;
  endtask

  task automatic run_to_done();
    for (int i = 0; i < 2000 && !done; i++) tick(1'b0);
    repeat (4) tick(1'b0);
  endtask

  task automatic check_counts(input string tag);
    chk(cnt_start == 1, {tag, " R2 start count"}, cnt_start, 1);
    chk(cnt_beat == N, {tag, " R7 beat count"}, cnt_beat, N);
    chk(cnt_done == 1, {tag, " R8 done count"}, cnt_done, 1);
    chk(done == 1'b1, {tag, " R6 done held"}, done, 1);
  endtask

  task automatic finish_up();
    $display("%0d/%0d checks passed", n_checks - n_fail, n_checks);
    $finish;
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    n_checks++; n_fail++;
    $display("FAIL watchdog: actual timeout expected completion");
    finish_up();
  end

  initial begin
    rst_n = 1'b0; go = 1'b0; ready = 1'b0;
    repeat (3) tick(1'b0);
    // R1: reset state, including two edges after release with go held
    chk(!beat_valid && !busy && !done && !ev_valid, "R1 reset outputs", {beat_valid, busy, done, ev_valid}, 0);
    #1 rst_n = 1'b1;
    tick(1'b1);
    tick(1'b0);
    chk(!busy && !ev_valid, "R1 go ignored during reset release", {busy, ev_valid}, 0);
    repeat (3) tick(1'b0);

    // Phase A: sink always ready
    mode = 0;
    cnt_start = 0; cnt_beat = 0; cnt_done = 0;
    tick(1'b1);
    tick(1'b0);
    chk(beat_valid && busy, "R2 valid and busy after go", {beat_valid, busy}, 2'b11);
    chk(ev_valid && ev_kind == 2'd1 && ev_index == 0 && ev_word == N, "R2 start record", ev_word, N);
    run_to_done();
    check_counts("A");
    // R10: go after done
    tick(1'b1);
    repeat (3) tick(1'b0);
    chk(cnt_start == 1 && !beat_valid && done, "R10 go after done ignored", cnt_start, 1);

    // Phase B: random backpressure, go while busy
    do_reset();
    mode = 1;
    tick(1'b1);
    repeat (10) tick(1'b0);
    tick(1'b1);
    tick(1'b0);
    chk(cnt_start == 1 && busy, "R10 go while busy ignored", cnt_start, 1);
    run_to_done();
    check_counts("B");

    // Phase C: slow sink, reset partway through
    do_reset();
    mode = 2;
    tick(1'b1);
    repeat (60) tick(1'b0);
    do_reset();
    chk(!beat_valid && !busy && !done, "R1 reset mid-transfer", {beat_valid, busy, done}, 0);
    tick(1'b1);
    run_to_done();
    check_counts("C");

    finish_up();
  end

endmodule